// File: doc/BRIEF.md
# Float Compare Exception-Flag Unit

This block takes two single-precision IEEE-754 operands and works out which IEEE exceptions a less-than comparison between them would raise. It returns those exceptions as an integer bit vector, not as a true/false result. Any operand with a zero exponent and a nonzero mantissa is treated as zero. When that happens, a dedicated input-flushed flag is set in the vector.

A swap control can exchange the operands before evaluation. This lets a less-than request be served by a greater-than datapath with identical flags. Writeback of the vector is gated by the least significant bit of a guard word. When that bit is clear, the destination keeps its old contents and the write-enable stays low. The unit is pipelined with one register stage. It accepts a new operation every cycle and returns the result one cycle later. It never touches any global sticky exception state.

Top module: `cmp_exc_unit`

## Requirements
- R1: The flag vector layout is fixed: bit 0 divide-by-zero, bit 1 inexact, bit 2 underflow, bit 3 overflow, bit 4 invalid (0x10), bit 5 input-flushed (0x20), bit 6 output-flushed. A comparison never sets bits 0-3 or bit 6, and every bit above 6 is zero.
- R2: If either operand is a NaN (all-ones exponent, nonzero mantissa; quiet or signalling), bit 4 is set.
- R3: If either operand is denormal (zero exponent, nonzero mantissa), it is flushed to zero and bit 5 is set.
- R4: A NaN together with a denormal on the other side gives 0x30.
- R5: Finite normal values, zeros of either sign, equal values and infinities of either sign give an all-zero vector.
- R6: With guard bit 0 equal to 1, `destWe` is high on the cycle after issue and `flagOut` carries the new vector. Guard bits 31..1 have no effect.
- R7: With guard bit 0 equal to 0, `destWe` is low on the cycle after issue and `flagOut` keeps its previous value.
- R8: The vector is identical whether `swapOps` is 0 or 1.
- R9: Latency is one cycle, and a new operation is accepted on every cycle without stalls.
- R10: While reset is asserted, `flagOut` and `destWe` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Issue strobe for one operation |
| opA | input | 32 | First single-precision operand |
| opB | input | 32 | Second single-precision operand |
| guardWord | input | 32 | Guard; only bit 0 enables writeback |
| swapOps | input | 1 | Exchange operands before evaluation |
| flagOut | output | 32 | Registered exception-flag vector |
| destWe | output | 1 | Destination write-enable, one cycle after issue |

## Verification
Some cases are hard to reach at full width: the joint NaN-and-denormal case, the boundary between the largest denormal and the smallest normal, and a held destination after a false guard in the middle of a back-to-back stream. Random 32-bit stimulus almost never lands on these. A second instance with a 3-bit exponent and 2-bit mantissa is therefore driven with every operand pair on consecutive cycles. The guard bit and the swap control vary with the pair index. A guard-false issue therefore falls between live writes, and every exponent and mantissa class meets every other. Directed full-width vectors cover the standard encodings such as infinities, quiet NaN and the smallest denormals.

// File: rtl/cmpx_pkg.sv
package cmpx_pkg;
  // Flag bit positions in the returned vector
  localparam int FLG_DBZ = 0;
  localparam int FLG_INX = 1;
  localparam int FLG_UNF = 2;
  localparam int FLG_OVF = 3;
  localparam int FLG_INV = 4;
  localparam int FLG_IFZ = 5;
  localparam int FLG_OFZ = 6;
  localparam int FLG_USED = 7;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // issue with guard true: load the flag register
    logic swap;     // exchange operands before classification
  } cmpxCtrl_t;
endpackage

// File: rtl/cmpx_classify.sv
module cmpx_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int DATA_W = 1 + EXP_W + MAN_W
) (
  input  logic [DATA_W-1:0] opnd,
  output logic              isNan,
  output logic              isDenorm
);
  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic             unusedSign;
  logic             expAllOnes;
  logic             expAllZero;
  logic             manNonZero;

  assign expField   = opnd[DATA_W-2 -: EXP_W];
  assign manField   = opnd[MAN_W-1:0];
  assign unusedSign = opnd[DATA_W-1];

  assign expAllOnes = &expField;
  assign expAllZero = ~|expField;
  assign manNonZero = |manField;

  assign isNan    = expAllOnes & manNonZero;
  assign isDenorm = expAllZero & manNonZero;
endmodule

// File: rtl/cmpx_control.sv
module cmpx_control
  import cmpx_pkg::*;
#(
  parameter int GUARD_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [GUARD_W-1:0] guardWord,
  input  logic               swapOps,
  output cmpxCtrl_t          ctrl,
  output logic               destWe
);
  logic guardTrue;
  logic unusedGuardHigh;

  assign guardTrue       = guardWord[0];
  assign unusedGuardHigh = ^guardWord[GUARD_W-1:1];

  always_comb begin
    ctrl.capture = inValid & guardTrue;
    ctrl.swap    = swapOps;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) destWe <= 1'b0;
    else        destWe <= ctrl.capture;
  end

  // R6
  we_follows_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && guardWord[0]) |=> destWe);
  // R7
  we_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    destWe |-> $past(inValid && guardWord[0]));
endmodule

// File: rtl/cmpx_datapath.sv
module cmpx_datapath
  import cmpx_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int FLAG_W = 32,
  localparam int DATA_W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmpxCtrl_t         ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [FLAG_W-1:0] flagOut
);
  logic [DATA_W-1:0] opnd [2];
  logic [1:0]        nanVec;
  logic [1:0]        denVec;
  logic [FLAG_W-1:0] flagNext;
  logic [FLAG_W-1:0] flagReg;

  // Swap places the right-hand operand first, as a greater-than evaluation would
  assign opnd[0] = ctrl.swap ? opB : opA;
  assign opnd[1] = ctrl.swap ? opA : opB;

  for (genvar k = 0; k < 2; k++) begin : g_cls
    cmpx_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .opnd    (opnd[k]),
      .isNan   (nanVec[k]),
      .isDenorm(denVec[k])
    );
  end

  always_comb begin
    flagNext          = '0;
    flagNext[FLG_INV] = |nanVec;
    flagNext[FLG_IFZ] = |denVec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           flagReg <= '0;
    else if (ctrl.capture) flagReg <= flagNext;
  end

  assign flagOut = flagReg;

  // R2
  nan_sets_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.capture && (|nanVec)) |=> flagReg[FLG_INV]);
  // R3
  den_sets_ifz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.capture && (|denVec)) |=> flagReg[FLG_IFZ]);
  // R5
  ordinary_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.capture && !(|nanVec) && !(|denVec)) |=> (flagReg == '0));
  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.capture |=> $stable(flagReg));
endmodule

// File: rtl/cmp_exc_unit.sv
module cmp_exc_unit
  import cmpx_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int FLAG_W = 32,
  parameter int GUARD_W = 32,
  localparam int DATA_W = 1 + EXP_W + MAN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [GUARD_W-1:0] guardWord,
  input  logic               swapOps,
  output logic [FLAG_W-1:0]  flagOut,
  output logic               destWe
);
  cmpxCtrl_t ctrl;

  cmpx_control #(.GUARD_W(GUARD_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .guardWord(guardWord),
    .swapOps  (swapOps),
    .ctrl     (ctrl),
    .destWe   (destWe)
  );

  cmpx_datapath #(.EXP_W(EXP_W), .MAN_W(MAN_W), .FLAG_W(FLAG_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .flagOut(flagOut)
  );

  // R1
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    destWe |-> (flagOut[FLAG_W-1:FLG_USED] == '0 && flagOut[FLG_OFZ] == 1'b0
                && flagOut[FLG_OVF:FLG_DBZ] == '0));
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (flagOut == '0 && !destWe));
endmodule

// File: tb/tb_cmp_exc_unit.sv
`timescale 1ns/1ps
module tb_cmp_exc_unit;
  localparam int SE = 3;
  localparam int SM = 2;
  localparam int SW = 1 + SE + SM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        fValid = 0, fSwap = 0;
  logic [31:0] fA = 0, fB = 0, fGuard = 0;
  logic [31:0] fFlags;
  logic        fWe;

  logic          sValid = 0, sSwap = 0;
  logic [SW-1:0] sA = 0, sB = 0;
  logic [31:0]   sGuard = 0;
  logic [31:0]   sFlags;
  logic          sWe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  cmp_exc_unit dut (
    .clk(clk), .rst_n(rst_n), .inValid(fValid), .opA(fA), .opB(fB),
    .guardWord(fGuard), .swapOps(fSwap), .flagOut(fFlags), .destWe(fWe)
  );

  cmp_exc_unit #(.EXP_W(SE), .MAN_W(SM)) dutSmall (
    .clk(clk), .rst_n(rst_n), .inValid(sValid), .opA(sA), .opB(sB),
    .guardWord(sGuard), .swapOps(sSwap), .flagOut(sFlags), .destWe(sWe)
  );

  function automatic bit isNanF(longint v, int ew, int mw);
    longint e = (v >> mw) & ((64'd1 << ew) - 1);
    longint m = v & ((64'd1 << mw) - 1);
    return (e == ((64'd1 << ew) - 1)) && (m != 0);
  endfunction

  function automatic bit isDenF(longint v, int ew, int mw);
    longint e = (v >> mw) & ((64'd1 << ew) - 1);
    longint m = v & ((64'd1 << mw) - 1);
    return (e == 0) && (m != 0);
  endfunction

  function automatic logic [31:0] expFlags(longint a, longint b, int ew, int mw);
    logic [31:0] r = 32'h0;
    if (isNanF(a, ew, mw) || isNanF(b, ew, mw)) r = r | 32'h10;
    if (isDenF(a, ew, mw) || isDenF(b, ew, mw)) r = r | 32'h20;
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  logic [31:0] fModel = 0;

  // One full-width issue, result checked one cycle later
  task automatic runFull(string tag, logic [31:0] a, logic [31:0] b,
                         logic [31:0] g, logic sw);
    logic [31:0] e;
    @(negedge clk);
    fValid = 1; fA = a; fB = b; fGuard = g; fSwap = sw;
    e = expFlags(longint'(a), longint'(b), 8, 23);
    if (g[0]) fModel = e;
    @(negedge clk);
    fValid = 0;
    check({tag, " we"}, {31'h0, fWe}, {31'h0, g[0]});
    check({tag, " flags"}, fFlags, fModel);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] sModel;
    logic        sExpWe;
    string       sTag;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 flags", fFlags, 32'h0);
    check("R10 we", {31'h0, fWe}, 32'h0);
    check("R10 small flags", sFlags, 32'h0);
    rst_n = 1;

    // R5: ordinary, equal, infinite, zero
    runFull("R5 3.0 vs 0.0", 32'h40400000, 32'h00000000, 32'h1, 0);
    runFull("R5 equal", 32'h40400000, 32'h40400000, 32'h1, 0);
    runFull("R5 +inf -inf", 32'h7f800000, 32'hff800000, 32'h1, 0);
    runFull("R5 inf inf", 32'h7f800000, 32'h7f800000, 32'h1, 1);
    runFull("R5 smallest normal", 32'h00800000, 32'h80000000, 32'h1, 0);
    // R2: NaN
    runFull("R2 qnan", 32'h40400000, 32'hffffffff, 32'h1, 0);
    runFull("R2 snan", 32'h7f800001, 32'h3f800000, 32'h1, 0);
    // R3: denormal
    runFull("R3 denorm", 32'h3f800000, 32'h00400000, 32'h1, 0);
    runFull("R3 min denorm", 32'h80000001, 32'h3f800000, 32'h1, 1);
    // R4: both
    runFull("R4 nan+den", 32'h7fc00000, 32'h007fffff, 32'h1, 0);
    // R7: guard false keeps destination (model holds 0x30)
    runFull("R7 guard0", 32'h3f800000, 32'h40400000, 32'hfffffffe, 0);
    // R6: upper guard bits ignored
    runFull("R6 guard hi", 32'h3f800000, 32'h40400000, 32'h80000001, 0);
    // R1: upper bits zero
    check("R1 upper bits", fFlags & 32'hffffff80, 32'h0);

    // R8/R9: exhaustive small sweep, back to back every cycle
    sModel = 0; sExpWe = 0; sTag = "";
    for (int i = 0; i <= 4096; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check({sTag, " we R9"}, {31'h0, sWe}, {31'h0, sExpWe});
        check({sTag, " flags R8"}, sFlags, sModel);
      end
      if (i < 4096) begin
        int a = i >> 6;
        int b = i & 63;
        logic g = ((i % 3) != 0);
        logic [31:0] e = expFlags(longint'(a), longint'(b), SE, SM);
        sValid = 1; sA = SW'(a); sB = SW'(b);
        sSwap = logic'((i >> 2) & 1);
        sGuard = {31'(i * 7), g};
        sExpWe = g;
        if (g) sModel = e;
        if (!g) sTag = "R7";
        else if (e == 32'h30) sTag = "R4";
        else if (e == 32'h10) sTag = "R2";
        else if (e == 32'h20) sTag = "R3";
        else sTag = "R5";
      end else begin
        sValid = 0;
      end
    end
    @(negedge clk);
    check("R7 idle hold", sFlags, sModel);
    check("R7 idle we", {31'h0, sWe}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule